// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the byte-wide bus of a NOR-style flash array and turns multi-cycle write sequences into single-cycle requests for the program and erase engines. The bus inputs are the address, the data byte and three active-low strobes: chip enable, write enable and output enable. All of them arrive asynchronously to the system clock. The strobes pass through a two-stage synchroniser. A bus write starts when chip enable and write enable are both low with output enable high. The address is captured when the write starts and the data when it ends.

Every command opens with two fixed unlock writes. Byte program needs one more command write, after which the next write carries the target address and data. An erase needs a setup command and a second unlock pair before the final chip or sector command. Any write that does not fit the expected step sends the decoder back to read mode without issuing a request. While the algorithm engine reports busy, bus writes are dropped and the decoder state is held.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, mode is 0 (read) and every request output is low.
- R2: A bus write is recognised only while chip enable and write enable are both low and output enable is high. A strobe cycle made while output enable is low changes neither the mode nor the requests.
- R3: The address is taken when the write becomes active. The data is taken when the write ends. Address or data changes in the middle of a write do not alter the address or data used.
- R4: Data AAh at command address 5555h moves mode 0 to mode 1. Data 55h at 2AAAh then moves it to mode 2.
- R5: In mode 2, a write to 5555h gives one of these results. F0h pulses req_reset and returns to mode 0. A0h gives mode 3 (program armed). 80h gives mode 4 (erase setup). Any other byte gives mode 0 with no request.
- R6: In mode 3, the next write of any address and data pulses req_prog. prog_addr carries all 17 address bits and prog_data carries the data. The mode returns to 0.
- R7: From mode 4, AAh at 5555h gives mode 5 and 55h at 2AAAh gives mode 6. In mode 6, 10h at 5555h pulses req_chip_erase.
- R8: In mode 6, 30h at any address pulses req_sector_erase. sector_num is set to address bits 16:14.
- R9: Command address comparisons use only address bits 14:0. Bits 15 and 16 have no effect there.
- R10: A write whose address or data does not match the expected step returns the mode to 0 with no request.
- R11: While engine_busy is high, bus writes produce no request and leave the mode unchanged.
- R12: If chip enable and write enable are already low when reset is released, that write is not recognised. A write needs a fresh start after reset.
- R13: Each request is a single-cycle pulse. At most one request is high in any cycle. The mode reads 0 in the cycle a request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 17 | Bus address |
| bus_data | input | 8 | Bus write data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| engine_busy | input | 1 | Program or erase operation running |
| req_prog | output | 1 | Byte program request pulse |
| prog_addr | output | 17 | Address to program |
| prog_data | output | 8 | Byte to program |
| req_chip_erase | output | 1 | Whole-array erase request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| sector_num | output | 3 | Sector to erase |
| req_reset | output | 1 | Return-to-read request pulse |
| mode | output | 3 | Decoder state code, encoding as in R4 to R7 |

## Verification
The bench uses the default configuration: 17 address bits, 8 data bits, 3 sector bits and two synchroniser stages. This small setup allows every data byte to be swept through the second unlock step and the command step. It also allows every sector to be erased with bit 15 set both ways and bit 16 toggled on the command addresses. Directed sequences cover mid-write address and data changes, the output-enable inhibit, busy blocking and strobes held low through reset release.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    M_READ   = 3'd0,
    M_UNLK1  = 3'd1,
    M_UNLK2  = 3'd2,
    M_PROG   = 3'd3,
    M_ESET   = 3'd4,
    M_EUNLK1 = 3'd5,
    M_EUNLK2 = 3'd6
  } mode_e;

  localparam int          CMD_AW    = 15;
  localparam logic [14:0] ADR_FIRST = 15'h5555;
  localparam logic [14:0] ADR_SECND = 15'h2AAA;
  localparam logic [7:0]  B_UNLK1   = 8'hAA;
  localparam logic [7:0]  B_UNLK2   = 8'h55;
  localparam logic [7:0]  B_RESET   = 8'hF0;
  localparam logic [7:0]  B_PROG    = 8'hA0;
  localparam logic [7:0]  B_ESET    = 8'h80;
  localparam logic [7:0]  B_CHIP    = 8'h10;
  localparam logic [7:0]  B_SECT    = 8'h30;
endpackage

// File: rtl/fcd_sync.sv
module fcd_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fcd_capture.sv
module fcd_capture #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic act, act_q, open_q;
  logic start, finish;

  assign act    = !ce_s && !we_s && oe_s;
  assign start  = act && !act_q;
  assign finish = act_q && !act && oe_s && open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b1;
      open_q   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      act_q    <= act;
      wr_valid <= finish;
      if (start)     open_q <= 1'b1;
      else if (!act) open_q <= 1'b0;
      if (start)  wr_addr <= addr_in;
      if (finish) wr_data <= data_in;
    end
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              req_prog,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              req_chip,
  output logic              req_sect,
  output logic [SECT_W-1:0] sect,
  output logic              req_reset,
  output mode_e             state
);
  localparam int SECT_LO = ADDR_W - SECT_W;

  mode_e nxt;
  logic  n_prog, n_chip, n_sect, n_rst;
  logic  at_first, at_secnd;

  assign at_first = wr_addr[CMD_AW-1:0] == ADR_FIRST;
  assign at_secnd = wr_addr[CMD_AW-1:0] == ADR_SECND;

  always_comb begin
    nxt    = state;
    n_prog = 1'b0;
    n_chip = 1'b0;
    n_sect = 1'b0;
    n_rst  = 1'b0;
    if (wr_valid && !busy) begin
      nxt = M_READ;
      case (state)
        M_READ:   if (at_first && wr_data == DATA_W'(B_UNLK1)) nxt = M_UNLK1;
        M_UNLK1:  if (at_secnd && wr_data == DATA_W'(B_UNLK2)) nxt = M_UNLK2;
        M_UNLK2:  if (at_first) begin
                    if (wr_data == DATA_W'(B_RESET))     n_rst = 1'b1;
                    else if (wr_data == DATA_W'(B_PROG)) nxt = M_PROG;
                    else if (wr_data == DATA_W'(B_ESET)) nxt = M_ESET;
                  end
        M_PROG:   n_prog = 1'b1;
        M_ESET:   if (at_first && wr_data == DATA_W'(B_UNLK1)) nxt = M_EUNLK1;
        M_EUNLK1: if (at_secnd && wr_data == DATA_W'(B_UNLK2)) nxt = M_EUNLK2;
        M_EUNLK2: if (at_first && wr_data == DATA_W'(B_CHIP)) n_chip = 1'b1;
                  else if (wr_data == DATA_W'(B_SECT))         n_sect = 1'b1;
        default:  nxt = M_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= M_READ;
      req_prog  <= 1'b0;
      req_chip  <= 1'b0;
      req_sect  <= 1'b0;
      req_reset <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      sect      <= '0;
    end else begin
      state     <= nxt;
      req_prog  <= n_prog;
      req_chip  <= n_chip;
      req_sect  <= n_sect;
      req_reset <= n_rst;
      if (n_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (n_sect) sect <= wr_addr[ADDR_W-1:SECT_LO];
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int SECT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              engine_busy,
  output logic              req_prog,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              req_chip_erase,
  output logic              req_sector_erase,
  output logic [SECT_W-1:0] sector_num,
  output logic              req_reset,
  output logic [2:0]        mode
);
  logic              rst_q;
  logic [2:0]        strb_s;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  mode_e             state;

  fcd_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  fcd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_strb (
    .clk(clk), .rst_n(rst_q), .d({oe_n, we_n, ce_n}), .q(strb_s)
  );

  fcd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_q),
    .ce_s(strb_s[0]), .we_s(strb_s[1]), .oe_s(strb_s[2]),
    .addr_in(bus_addr), .data_in(bus_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_seq (
    .clk(clk), .rst_n(rst_q),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(engine_busy),
    .req_prog(req_prog), .prog_addr(prog_addr), .prog_data(prog_data),
    .req_chip(req_chip_erase), .req_sect(req_sector_erase),
    .sect(sector_num), .req_reset(req_reset), .state(state)
  );

  assign mode = state;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       engine_busy,
  input logic       req_prog,
  input logic       req_chip_erase,
  input logic       req_sector_erase,
  input logic       req_reset,
  input logic [2:0] mode
);
  logic any_req;
  assign any_req = req_prog || req_chip_erase || req_sector_erase || req_reset;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_prog, req_chip_erase, req_sector_erase, req_reset})); // R13
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req); // R13
  AST_REQ_MODE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> mode == 3'd0); // R13
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(engine_busy) |-> !any_req); // R11
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |=> $stable(mode)); // R11
  AST_PROG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    req_prog |-> $past(mode) == 3'd3); // R6
  AST_ERASE_FROM_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_chip_erase || req_sector_erase) |-> $past(mode) == 3'd6); // R7 R8
  AST_RESET_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_reset |-> $past(mode) == 3'd2); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 3'd7); // R10
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .engine_busy(engine_busy),
  .req_prog(req_prog), .req_chip_erase(req_chip_erase),
  .req_sector_erase(req_sector_erase), .req_reset(req_reset), .mode(mode)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] bus_addr;
  logic [7:0]  bus_data;
  logic        ce_n, we_n, oe_n, engine_busy;
  logic        req_prog, req_chip_erase, req_sector_erase, req_reset;
  logic [16:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  sector_num, mode;

  int total = 0, bad = 0;
  int n_prog = 0, n_chip = 0, n_sect = 0, n_rst = 0, n_multi = 0;
  logic [16:0] last_pa;
  logic [7:0]  last_pd;
  logic [2:0]  last_sec;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .engine_busy(engine_busy),
    .req_prog(req_prog), .prog_addr(prog_addr), .prog_data(prog_data),
    .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
    .sector_num(sector_num), .req_reset(req_reset), .mode(mode)
  );

  always @(posedge clk) begin
    if (req_prog) begin n_prog++; last_pa = prog_addr; last_pd = prog_data; end
    if (req_chip_erase) n_chip++;
    if (req_sector_erase) begin n_sect++; last_sec = sector_num; end
    if (req_reset) n_rst++;
    if (32'(req_prog) + 32'(req_chip_erase) + 32'(req_sector_erase) + 32'(req_reset) > 1)
      n_multi++;
  end

  function automatic int nreq();
    return n_prog + n_chip + n_sect + n_rst;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic bwrite(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_data = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic unlock(input logic [16:0] hi);
    bwrite(hi | 17'h05555, 8'hAA);
    bwrite(hi | 17'h02AAA, 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r0;
    engine_busy = 1'b0; bus_addr = '0; bus_data = '0;
    do_reset();
    // R1 reset state
    chk(mode == 0, "R1 mode", mode, 0);
    chk({req_prog, req_chip_erase, req_sector_erase, req_reset} == 4'b0, "R1 req",
        {req_prog, req_chip_erase, req_sector_erase, req_reset}, 0);

    // R4 R10 sweep of second unlock byte
    for (int d = 0; d < 256; d++) begin
      do_reset(); r0 = nreq();
      bwrite(17'h05555, 8'hAA);
      chk(mode == 1, "R4 first unlock", mode, 1);
      bwrite(17'h02AAA, 8'(d));
      chk(mode == (d == 8'h55 ? 3'd2 : 3'd0), "R4 R10 second unlock", mode, d == 8'h55 ? 2 : 0);
      chk(nreq() == r0, "R10 no request", nreq() - r0, 0);
    end

    // R5 sweep of command byte
    for (int d = 0; d < 256; d++) begin
      int em, er;
      do_reset(); r0 = n_rst;
      unlock(17'h0);
      bwrite(17'h05555, 8'(d));
      em = (d == 8'hA0) ? 3 : (d == 8'h80) ? 4 : 0;
      er = (d == 8'hF0) ? 1 : 0;
      chk(mode == 3'(em), "R5 command mode", mode, em);
      chk(n_rst - r0 == er, "R5 reset request", n_rst - r0, er);
    end

    // R10 wrong address for command step
    do_reset(); r0 = nreq();
    unlock(17'h0); bwrite(17'h02AAA, 8'hA0);
    chk(mode == 0 && nreq() == r0, "R10 command address", mode, 0);

    // R6 R3 program with bit 16 and mid-write change
    do_reset(); r0 = n_prog;
    unlock(17'h10000); bwrite(17'h15555, 8'hA0);
    chk(mode == 3, "R9 armed with high bits", mode, 3);
    @(negedge clk);
    bus_addr = 17'h1ABCD; bus_data = 8'h11; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_addr = 17'h00123; bus_data = 8'h5C;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_prog - r0 == 1, "R6 program request", n_prog - r0, 1);
    chk(last_pa == 17'h1ABCD, "R3 address at start", last_pa, 17'h1ABCD);
    chk(last_pd == 8'h5C, "R3 data at end", last_pd, 8'h5C);
    chk(mode == 0, "R6 back to read", mode, 0);

    // R7 chip erase with bits 15/16 set on command addresses
    do_reset(); r0 = n_chip;
    unlock(17'h18000); bwrite(17'h1D555, 8'h80);
    chk(mode == 4, "R7 erase setup", mode, 4);
    bwrite(17'h0D555, 8'hAA);
    chk(mode == 5, "R7 second unlock a", mode, 5);
    bwrite(17'h1AAAA, 8'h55);
    chk(mode == 6, "R7 second unlock b", mode, 6);
    bwrite(17'h15555, 8'h10);
    chk(n_chip - r0 == 1 && mode == 0, "R7 chip erase", n_chip - r0, 1);

    // R8 R9 every sector, bit 15 both ways on command addresses
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 2; b++) begin
        logic [16:0] hi;
        hi = {s[0], b[0], 15'h0};
        do_reset(); r0 = n_sect;
        unlock(hi); bwrite(hi | 17'h05555, 8'h80); unlock(hi);
        bwrite({s[2:0], 14'h0123}, 8'h30);
        chk(n_sect - r0 == 1, "R8 sector request", n_sect - r0, 1);
        chk(last_sec == s[2:0], "R8 sector number", last_sec, s);
      end
    end

    // R10 mismatch in erase path
    do_reset(); r0 = nreq();
    unlock(17'h0); bwrite(17'h05555, 8'h80); bwrite(17'h02AAA, 8'hAA);
    chk(mode == 0 && nreq() == r0, "R10 erase unlock mismatch", mode, 0);
    do_reset(); r0 = nreq();
    unlock(17'h0); bwrite(17'h05555, 8'h80); unlock(17'h0); bwrite(17'h00000, 8'h10);
    chk(mode == 0 && nreq() == r0, "R10 chip command off address", nreq() - r0, 0);

    // R2 output enable low inhibits
    do_reset();
    oe_n = 1'b0; bwrite(17'h05555, 8'hAA); oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mode == 0, "R2 oe inhibit", mode, 0);
    bwrite(17'h05555, 8'hAA);
    chk(mode == 1, "R2 normal write", mode, 1);

    // R11 busy blocks writes
    do_reset(); r0 = nreq();
    unlock(17'h0);
    engine_busy = 1'b1;
    bwrite(17'h05555, 8'hF0);
    chk(mode == 2, "R11 mode held", mode, 2);
    chk(nreq() == r0, "R11 no request", nreq() - r0, 0);
    engine_busy = 1'b0;
    bwrite(17'h05555, 8'hF0);
    chk(n_rst > 0 && nreq() == r0 + 1 && mode == 0, "R11 after busy", nreq() - r0, 1);

    // R12 strobes low across reset release
    rst_n = 1'b0; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    bus_addr = 17'h05555; bus_data = 8'hAA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(mode == 0, "R12 held write ignored", mode, 0);
    bwrite(17'h05555, 8'hAA);
    chk(mode == 1, "R12 fresh write", mode, 1);

    // R13 never more than one request at once
    chk(n_multi == 0, "R13 exclusive", n_multi, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule